// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO Chain

This block is a dual-clock FIFO stage that presents its oldest word at the output without waiting for a read request. Two active-low handshake flags carry all flow control. The input-ready flag is low while a location is free. The output-ready flag is low while a valid word sits on the output. The write and read enables are active low as well. Because of these polarities, one stage's output-ready can drive the next stage's write enable directly. In the same way, the next stage's input-ready drives the previous stage's read enable, and no glue logic is needed between stages.

The top level chains `STAGES` identical stages. The first stage writes on the write clock, the last stage reads on the read clock, and every inner hop runs on a shared transfer clock. A word written into an empty chain ripples forward on its own until it reaches the last output. A slot freed by reading a full chain bubbles backward until the first stage can accept another word. Each stage holds `DEPTH` words in its array plus one in its output register, so the capacity of the chain is the sum of the stage capacities. All clocks must run continuously.

Top module: `cfifo_chain`

## Requirements
- R1: A word written into an empty chain appears on `dout_o` with `or_no` low, without any read request.
- R2: While `rst_ni` is low, `ir_no` is 0 and `or_no` is 1, and all stored words are discarded. After release, nothing appears on the output until a new write is made.
- R3: A write is accepted on a rising write-clock edge when `wen_ni` is 0 and `ir_no` is 0 at that edge.
- R4: While `or_no` is 0 and `ren_ni` is 1, `dout_o` holds its value. A read, meaning `ren_ni` is 0 while `or_no` is 0, removes the word, and `or_no` rises at once if no further word is available.
- R5: Words leave the chain in exactly the order in which they were accepted, and every accepted word leaves exactly once.
- R6: A chain that is filled and given time to settle accepts exactly `STAGES*(DEPTH+1)` words before `ir_no` stays high.
- R7: A write attempted while `ir_no` is 1 is ignored. It neither stores a word nor moves the write pointer.
- R8: A read attempted while `or_no` is 1 is ignored. It neither drops a word nor moves the read pointer.
- R9: When all clocks are the same clock, `or_no` falls after the edge that comes 4*(STAGES-1)+3 cycles after the edge that accepted the first word into an empty chain.
- R10: Once the chain holds enough words, writing and reading on every cycle keeps `or_no` low continuously, so each word adds no extra latency.
- R11: Reading one word from a full, settled chain lets exactly one further write be accepted once the freed slot has moved back to the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock of the first stage |
| xclk_i | input | 1 | Transfer clock shared by the hops between stages |
| rclk_i | input | 1 | Read clock of the last stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_ni | input | 1 | Write enable, active low |
| din_i | input | DW | Write data |
| ir_no | output | 1 | Input ready, low while a write can be accepted |
| ren_ni | input | 1 | Read enable, active low |
| dout_o | output | DW | Oldest word in the chain |
| or_no | output | 1 | Output ready, low while `dout_o` is valid |

## Verification
The bench keeps a reference queue and compares the oldest entry with `dout_o` on every cycle in which the output claims to be valid. A chain that lost, duplicated or reordered a word at a stage boundary would fail this comparison. Further checks target several corner cases:
- The exact ripple latency of the first word. An extra or a missing synchronizer stage, or a stage that needed a read before it showed data, would shift this count.
- Writes offered against a full chain and reads offered against an empty one. A design that moved a pointer past a flag would overflow or replay stale data and miscount the capacity.
- A single bubble travelling back from the output, continuous streaming, and a reset in the middle of a run. A design that kept words through reset would show them afterwards.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  localparam int unsigned MIN_DEPTH = 4;

  function automatic int unsigned bin2gray(input int unsigned b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/cfifo_sync.sv
module cfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cfifo_wr_ctl.sv
module cfifo_wr_ctl
  import cfifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        wclk_i,
  input  logic        rst_ni,
  input  logic        wen_ni,
  input  logic [AW:0] rgray_s_i,
  output logic        push_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wgray_o,
  output logic [AW:0] wbin_o,
  output logic        ir_no
);
  localparam int PW = AW + 1;

  logic [AW:0] wbin_q, wgray_q, wbin_d;
  logic        full;

  // full: pointers differ only in the two top gray bits
  assign full    = (wgray_q == {~rgray_s_i[AW:AW-1], rgray_s_i[AW-2:0]});
  assign push_o  = ~wen_ni & ~full;
  assign wbin_d  = wbin_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push_o) begin
      wbin_q  <= wbin_d;
      wgray_q <= PW'(bin2gray(32'(wbin_d)));
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign wbin_o  = wbin_q;
  assign ir_no   = full;
endmodule

// File: rtl/cfifo_rd_ctl.sv
module cfifo_rd_ctl
  import cfifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ren_ni,
  input  logic [AW:0]   wgray_s_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [AW:0]   rbin_o,
  output logic [DW-1:0] dout_o,
  output logic          or_no
);
  localparam int PW = AW + 1;

  logic [AW:0]   rbin_q, rgray_q, rbin_d;
  logic [DW-1:0] dout_q;
  logic          vld_q, empty, pop, fetch;

  assign empty  = (rgray_q == wgray_s_i);
  assign pop    = vld_q & ~ren_ni;
  // fall-through: refill the output register whenever it is free or being drained
  assign fetch  = ~empty & (~vld_q | pop);
  assign rbin_d = rbin_q + PW'(1);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      vld_q   <= 1'b0;
      dout_q  <= '0;
    end else begin
      if (fetch) begin
        rbin_q  <= rbin_d;
        rgray_q <= PW'(bin2gray(32'(rbin_d)));
        dout_q  <= rdata_i;
      end
      vld_q <= fetch | (vld_q & ~pop);
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign rbin_o  = rbin_q;
  assign dout_o  = dout_q;
  assign or_no   = ~vld_q;
endmodule

// File: rtl/cfifo_stage.sv
module cfifo_stage #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [DW-1:0] din_i,
  output logic          ir_no,
  input  logic          ren_ni,
  output logic [DW-1:0] dout_o,
  output logic          or_no
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s, wbin, rbin;
  logic [DW-1:0] rdata;
  logic          push;

  cfifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .wen_ni    (wen_ni),
    .rgray_s_i (rgray_s),
    .push_o    (push),
    .waddr_o   (waddr),
    .wgray_o   (wgray),
    .wbin_o    (wbin),
    .ir_no     (ir_no)
  );

  cfifo_sync #(.W(AW + 1)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  cfifo_sync #(.W(AW + 1)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  always_ff @(posedge wclk_i) begin
    if (push) mem_q[waddr] <= din_i;
  end

  assign rdata = mem_q[raddr];

  cfifo_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i    (rclk_i),
    .rst_ni    (rst_ni),
    .ren_ni    (ren_ni),
    .wgray_s_i (wgray_s),
    .rdata_i   (rdata),
    .raddr_o   (raddr),
    .rgray_o   (rgray),
    .rbin_o    (rbin),
    .dout_o    (dout_o),
    .or_no     (or_no)
  );
endmodule

// File: rtl/cfifo_chain.sv
module cfifo_chain #(
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int STAGES = 3
) (
  input  logic          wclk_i,
  input  logic          xclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [DW-1:0] din_i,
  output logic          ir_no,
  input  logic          ren_ni,
  output logic [DW-1:0] dout_o,
  output logic          or_no
);
  // vld_n[k]: write enable of stage k / output ready of stage k-1
  // rdy_n[k]: input ready of stage k / read enable of stage k-1
  logic [DW-1:0] dat [STAGES+1];
  logic [STAGES:0] vld_n, rdy_n;

  assign dat[0]        = din_i;
  assign vld_n[0]      = wen_ni;
  assign rdy_n[STAGES] = ren_ni;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cfifo_stage #(.DW(DW), .DEPTH(DEPTH)) u_stage (
      .wclk_i (k == 0 ? wclk_i : xclk_i),
      .rclk_i (k == STAGES - 1 ? rclk_i : xclk_i),
      .rst_ni (rst_ni),
      .wen_ni (vld_n[k]),
      .din_i  (dat[k]),
      .ir_no  (rdy_n[k]),
      .ren_ni (rdy_n[k+1]),
      .dout_o (dat[k+1]),
      .or_no  (vld_n[k+1])
    );
  end

  assign ir_no  = rdy_n[0];
  assign dout_o = dat[STAGES];
  assign or_no  = vld_n[STAGES];
endmodule

// File: rtl/cfifo_chk.sv
module cfifo_stage_chk #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          ren_ni,
  input logic          ir_no,
  input logic          or_no,
  input logic [DW-1:0] dout_i,
  input logic [AW:0]   wptr_i,
  input logic [AW:0]   rptr_i
);
  // R2: flags leave reset in their idle state
  a_r2_reset_rd_flag: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> or_no);
  a_r2_reset_wr_flag: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !ir_no);

  // R4: an unread valid word stays put
  a_r4_hold_output: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!or_no && ren_ni) |=> (!or_no && $stable(dout_i)));

  // R7: no pointer movement while full
  a_r7_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ir_no |=> $stable(wptr_i));

  // R8: read pointer moves only when a word becomes valid
  a_r8_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    or_no |=> (!or_no || $stable(rptr_i)));
endmodule

bind cfifo_stage cfifo_stage_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i (wclk_i),
  .rclk_i (rclk_i),
  .rst_ni (rst_ni),
  .ren_ni (ren_ni),
  .ir_no  (ir_no),
  .or_no  (or_no),
  .dout_i (dout_o),
  .wptr_i (wbin),
  .rptr_i (rbin)
);

// File: tb/tb_cfifo_chain.sv
module tb_cfifo_chain;
  localparam int CLK_NS = 10;
  localparam int DW     = 16;
  localparam int DEPTH  = 8;
  localparam int STAGES = 3;
  localparam int CAP    = STAGES * (DEPTH + 1);
  localparam int LAT    = 4 * (STAGES - 1) + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wen_ni = 1'b1;
  logic ren_ni = 1'b1;
  logic [DW-1:0] din = '0;
  logic ir_no, or_no;
  logic [DW-1:0] dout;

  int total = 0;
  int bad = 0;
  int acc_w = 0;
  int acc_r = 0;
  bit done = 1'b0;
  logic [DW-1:0] q[$];

  always #(CLK_NS / 2) clk = ~clk;

  cfifo_chain #(.DW(DW), .DEPTH(DEPTH), .STAGES(STAGES)) dut (
    .wclk_i (clk),
    .xclk_i (clk),
    .rclk_i (clk),
    .rst_ni (rst_ni),
    .wen_ni (wen_ni),
    .din_i  (din),
    .ir_no  (ir_no),
    .ren_ni (ren_ni),
    .dout_o (dout),
    .or_no  (or_no)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: compare front, drive at negedge, update model at the edge
  task automatic step(input bit w, input logic [DW-1:0] d, input bit r);
    bit wa, ra;
    if (!or_no) begin
      if (q.size() == 0) chk(1'b0, "R5 valid output with empty model", 1, 0);
      else chk(dout == q[0], "R5 output order", dout, q[0]);
    end
    wen_ni = !w;
    din    = d;
    ren_ni = !r;
    wa = w && !ir_no;
    ra = r && !or_no;
    @(posedge clk);
    if (ra && q.size() > 0) begin
      void'(q.pop_front());
      acc_r++;
    end
    if (wa) begin
      q.push_back(d);
      acc_w++;
    end
    @(negedge clk);
    wen_ni = 1'b1;
    ren_ni = 1'b1;
  endtask

  task automatic drain();
    for (int g = 0; g < 1000 && q.size() > 0; g++) step(1'b0, '0, 1'b1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    logic [DW-1:0] d0;
    int lat;
    int stall;

    repeat (3) @(negedge clk);
    chk(ir_no == 1'b0 && or_no == 1'b1, "R2 flags in reset", {ir_no, or_no}, 1);
    rst_ni = 1'b1;
    repeat (2) step(1'b0, '0, 1'b0);

    // R1 / R3 / R9: fall-through latency of the first word
    acc_w = 0;
    step(1'b1, 16'h1234, 1'b0);
    chk(acc_w == 1, "R3 write accepted with ir_no low", acc_w, 1);
    lat = 0;
    while (or_no && lat < 100) begin
      step(1'b0, '0, 1'b0);
      lat++;
    end
    chk(!or_no, "R1 output valid without read", or_no, 0);
    chk(dout == 16'h1234, "R1 fall-through data", dout, 16'h1234);
    chk(lat == LAT, "R9 ripple latency", lat, LAT);

    // R4: hold then advance
    d0 = dout;
    repeat (5) step(1'b0, '0, 1'b0);
    chk(!or_no && dout == d0, "R4 output held", dout, d0);
    step(1'b0, '0, 1'b1);
    chk(or_no == 1'b1, "R4 read empties output", or_no, 1);

    // R8: reads on empty output are ignored
    acc_r = 0;
    repeat (5) step(1'b0, '0, 1'b1);
    chk(acc_r == 0, "R8 no pop while or_no high", acc_r, 0);
    step(1'b1, 16'h00ab, 1'b0);
    repeat (LAT + 2) step(1'b0, '0, 1'b0);
    chk(!or_no && dout == 16'h00ab, "R8 next word intact", dout, 16'h00ab);
    drain();

    // R6 / R7: fill until input stalls, writes while full are dropped
    acc_w = 0;
    stall = 0;
    for (int i = 0; i < 400 && stall < 30; i++) begin
      step(1'b1, DW'(16'h0100 + i), 1'b0);
      if (ir_no) stall++;
      else stall = 0;
    end
    chk(acc_w == CAP, "R6 chain capacity", acc_w, CAP);
    chk(q.size() == CAP && ir_no, "R7 writes while full dropped", q.size(), CAP);

    // R11: one read frees exactly one slot at the input
    step(1'b0, '0, 1'b1);
    acc_w = 0;
    for (int i = 0; i < 40; i++) step(1'b1, DW'(16'h0700 + i), 1'b0);
    chk(acc_w == 1, "R11 bubble admits one word", acc_w, 1);

    acc_r = 0;
    drain();
    chk(acc_r == CAP, "R5 drained count", acc_r, CAP);
    repeat (3) step(1'b0, '0, 1'b1);
    chk(or_no == 1'b1, "R5 empty after drain", or_no, 1);

    // R10: continuous streaming
    for (int i = 0; i < 24; i++) step(1'b1, DW'(16'h2000 + i), 1'b0);
    repeat (40) step(1'b0, '0, 1'b0);
    for (int i = 0; i < 40; i++) begin
      chk(!or_no, "R10 output stays valid while streaming", or_no, 0);
      step(1'b1, DW'(16'h3000 + i), 1'b1);
    end
    drain();
    chk(q.size() == 0, "R10 stream drained", q.size(), 0);

    // R2: reset in the middle of a run discards contents
    for (int i = 0; i < 5; i++) step(1'b1, DW'(16'h4000 + i), 1'b0);
    repeat (3) step(1'b0, '0, 1'b0);
    rst_ni = 1'b0;
    step(1'b0, '0, 1'b0);
    chk(ir_no == 1'b0 && or_no == 1'b1, "R2 flags in mid-run reset", {ir_no, or_no}, 1);
    q.delete();
    rst_ni = 1'b1;
    repeat (LAT + 5) step(1'b0, '0, 1'b0);
    chk(or_no == 1'b1, "R2 contents discarded", or_no, 1);

    summary();
  end
endmodule